// File: doc/BRIEF.md
# Subtractive-Decode Write Target

This block sits on a primary parallel bus as the catch-all agent for memory writes. After each address phase carrying a memory-write command it watches the select line driven by the other agents for a fixed window. If none of them answers, it takes the cycle with its own device select. It then either terminates the write with a retry or accepts it and forwards it to a secondary bus. The block claims by elimination, so it never compares the address against a range: any address that nobody else wanted is taken.

The secondary bus is modelled as a busy flag, a request/grant pair and a start/done write handshake. A write is retried when a registered lock input is high. It is also retried when the secondary bus is occupied by another master or a DMA engine. An occupancy retry raises a request for the secondary bus. Once the grant arrives, the next attempt is accepted even if the busy flag is still set. An accepted write holds the primary bus in wait states until the secondary write finishes. If the secondary side never signals done, the write still ends after a fixed standard length.

Top module: `subtractive_wr_target`

## Requirements
- R1: An address phase (`ap_valid` high) with command `4'b0111` (memory write) is claimed when `other_sel` is low at each of the three clock edges that follow the address edge. `devsel` is high from the third of those edges on, whatever the value of `ap_addr`.
- R2: If `other_sel` is high at any of those three edges, the block does not drive `devsel`, `stop` or `trdy` for that cycle.
- R3: An address phase whose command is not `4'b0111` is ignored: `devsel`, `stop`, `trdy` and `sec_start` stay low.
- R4: A claimed write is retried if the secondary bus is occupied (`sec_busy` high at the claim edge) and no grant is held. Retry means `stop` and `devsel` high together for exactly one clock, with `trdy` and `sec_start` low. The clock after that, `stop` and `devsel` are both low.
- R5: An occupancy retry sets `sec_req` at the claim edge. `sec_req` stays high until an edge at which `sec_gnt` is high, and it is low after that edge.
- R6: Once a grant has been seen, the next claimed write is accepted even if `sec_busy` is high. The held grant is consumed when that write completes.
- R7: `lock_in` is registered. While it is high, every claimed write is retried, and the retry raises no `sec_req` when the secondary bus is free.
- R8: An accepted write pulses `sec_start` for one clock, starting at the claim edge. In that clock `sec_addr` and `sec_data` carry the write's address and data. `devsel` is high and `trdy` low until the secondary write ends.
- R9: The secondary write ends at the edge where `sec_done` is sampled high. `trdy` is then high for exactly one clock. At the following edge `devsel` and `trdy` both fall.
- R10: If `sec_done` never comes, the secondary write ends at the fourth edge after the claim edge (standard length `STD_LEN` = 4), and `trdy` follows as in R9.
- R11: After reset `devsel`, `stop`, `trdy`, `sec_start` and `sec_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ap_valid | input | 1 | Address-phase strobe, one clock |
| ap_cmd | input | 4 | Bus command in the address phase |
| ap_addr | input | ADDR_W | Address in the address phase |
| wr_data | input | DATA_W | Write data, held through the claim |
| other_sel | input | 1 | Device select from any other agent |
| lock_in | input | 1 | Lock request, registered inside |
| devsel | output | 1 | This agent's device select |
| stop | output | 1 | Retry termination |
| trdy | output | 1 | Target ready, ends the data phase |
| sec_busy | input | 1 | Secondary bus owned by another master or DMA |
| sec_gnt | input | 1 | Grant of the secondary bus |
| sec_req | output | 1 | Request for the secondary bus |
| sec_start | output | 1 | Start pulse of a secondary write |
| sec_addr | output | ADDR_W | Secondary write address |
| sec_data | output | DATA_W | Secondary write data |
| sec_done | input | 1 | Secondary write completed |

## Verification
Two behaviours can fall in the same clock. One is the claim decision at the end of the select window. The other is the secondary-bus occupancy that decides retry against accept. The bench provokes this by holding `sec_busy` high across the claim edge, both with and without a held grant. A retry is judged by `stop` and `sec_req` appearing together with `devsel`. An accept is judged by `sec_start` appearing with the latched address and data. The end of a transfer is also exercised from both sides: once by a `sec_done` pulse, and once by the standard-length timeout, each followed by the single `trdy` clock and the release of `devsel`.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RETRY,
    ST_XFER,
    ST_DATA
  } swb_state_e;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

  function automatic logic is_mem_write(input logic [3:0] cmd);
    return cmd == CMD_MEM_WRITE;
  endfunction

  // true when a zero-based counter stands on the last slot of a window of lim clocks
  function automatic logic window_last(input int cnt, input int lim);
    return cnt == lim - 1;
  endfunction

  function automatic logic must_retry(input logic lock, input logic busy, input logic granted);
    return lock | (busy & ~granted);
  endfunction
endpackage

// File: rtl/swb_capture.sv
module swb_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_take,
  input  logic              claim_evt,
  input  logic [ADDR_W-1:0] ap_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] sec_addr,
  output logic [DATA_W-1:0] sec_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_addr <= '0;
      sec_data <= '0;
    end else begin
      if (ap_take)   sec_addr <= ap_addr;
      if (claim_evt) sec_data <= wr_data;
    end
  end
endmodule

// File: rtl/swb_req_track.sv
module swb_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic retry_busy_evt,
  input  logic sec_gnt,
  input  logic done_evt,
  output logic sec_req,
  output logic granted
);
  logic gnt_seen;
  assign gnt_seen = sec_req & sec_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_req <= 1'b0;
      granted <= 1'b0;
    end else begin
      if (gnt_seen)            sec_req <= 1'b0;
      else if (retry_busy_evt) sec_req <= 1'b1;
      if (gnt_seen)            granted <= 1'b1;
      else if (done_evt)       granted <= 1'b0;
    end
  end
endmodule

// File: rtl/swb_fsm.sv
module swb_fsm
  import swb_pkg::*;
#(
  parameter int SEL_WIN = 3,
  parameter int STD_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ap_valid,
  input  logic [3:0] ap_cmd,
  input  logic       other_sel,
  input  logic       lock_q,
  input  logic       sec_busy,
  input  logic       granted,
  input  logic       sec_done,
  output logic       devsel,
  output logic       stop,
  output logic       trdy,
  output logic       sec_start,
  output logic       ap_take,
  output logic       claim_evt,
  output logic       win_abort,
  output logic       retry_busy_evt,
  output logic       xfer_timeout,
  output logic       done_evt
);
  localparam int MAXW = (SEL_WIN > STD_LEN) ? SEL_WIN : STD_LEN;
  localparam int CW   = $clog2(MAXW + 1);

  swb_state_e    state;
  logic [CW-1:0] cnt;
  logic          win_last, retry_now, xfer_end;

  always_comb begin
    ap_take        = (state == ST_IDLE) && ap_valid && is_mem_write(ap_cmd);
    win_abort      = (state == ST_WAIT) && other_sel;
    win_last       = (state == ST_WAIT) && !other_sel && window_last(int'(cnt), SEL_WIN);
    claim_evt      = win_last;
    retry_now      = must_retry(lock_q, sec_busy, granted);
    retry_busy_evt = win_last && retry_now && sec_busy && !granted;
    xfer_timeout   = (state == ST_XFER) && !sec_done && window_last(int'(cnt), STD_LEN);
    xfer_end       = (state == ST_XFER) && (sec_done || xfer_timeout);
    done_evt       = (state == ST_DATA);
    devsel         = (state == ST_RETRY) || (state == ST_XFER) || (state == ST_DATA);
    stop           = (state == ST_RETRY);
    trdy           = (state == ST_DATA);
    sec_start      = (state == ST_XFER) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (ap_take) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (win_abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (win_last) begin
            state <= retry_now ? ST_RETRY : ST_XFER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RETRY: state <= ST_IDLE;
        ST_XFER: begin
          if (xfer_end) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subtractive_wr_target.sv
module subtractive_wr_target #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SEL_WIN = 3,
  parameter int STD_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_valid,
  input  logic [3:0]        ap_cmd,
  input  logic [ADDR_W-1:0] ap_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              other_sel,
  input  logic              lock_in,
  output logic              devsel,
  output logic              stop,
  output logic              trdy,
  input  logic              sec_busy,
  input  logic              sec_gnt,
  output logic              sec_req,
  output logic              sec_start,
  output logic [ADDR_W-1:0] sec_addr,
  output logic [DATA_W-1:0] sec_data,
  input  logic              sec_done
);
  logic lock_q, granted;
  logic ap_take, claim_evt, win_abort, retry_busy_evt, xfer_timeout, done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_in;
  end

  swb_fsm #(.SEL_WIN(SEL_WIN), .STD_LEN(STD_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ap_valid(ap_valid), .ap_cmd(ap_cmd),
    .other_sel(other_sel), .lock_q(lock_q), .sec_busy(sec_busy),
    .granted(granted), .sec_done(sec_done), .devsel(devsel), .stop(stop),
    .trdy(trdy), .sec_start(sec_start), .ap_take(ap_take),
    .claim_evt(claim_evt), .win_abort(win_abort),
    .retry_busy_evt(retry_busy_evt), .xfer_timeout(xfer_timeout),
    .done_evt(done_evt)
  );

  swb_req_track u_req (
    .clk(clk), .rst_n(rst_n), .retry_busy_evt(retry_busy_evt),
    .sec_gnt(sec_gnt), .done_evt(done_evt), .sec_req(sec_req),
    .granted(granted)
  );

  swb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ap_take(ap_take), .claim_evt(claim_evt),
    .ap_addr(ap_addr), .wr_data(wr_data), .sec_addr(sec_addr),
    .sec_data(sec_data)
  );
endmodule

// File: rtl/swb_checker.sv
module swb_checker (
  input logic clk,
  input logic rst_n,
  input logic other_sel,
  input logic devsel,
  input logic stop,
  input logic trdy,
  input logic sec_start,
  input logic sec_req,
  input logic sec_gnt,
  input logic win_abort
);
  assert_claim_clear_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel) |-> !$past(other_sel));
  assert_abort_no_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_abort |=> !devsel);
  assert_retry_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !stop && !devsel);
  assert_retry_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> devsel && !trdy && !sec_start);
  assert_req_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req && !sec_gnt |=> sec_req);
  assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req && sec_gnt |=> !sec_req);
  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_start |-> devsel && !trdy);
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_start |=> !sec_start);
  assert_trdy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |=> !trdy && !devsel);
  assert_trdy_with_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |-> devsel);
endmodule

bind subtractive_wr_target swb_checker u_swb_checker (
  .clk(clk), .rst_n(rst_n), .other_sel(other_sel), .devsel(devsel),
  .stop(stop), .trdy(trdy), .sec_start(sec_start), .sec_req(sec_req),
  .sec_gnt(sec_gnt), .win_abort(win_abort)
);

// File: tb/subtractive_wr_target_bench.sv
module subtractive_wr_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MEMW = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ap_valid = 1'b0;
  logic [3:0]  ap_cmd = '0;
  logic [31:0] ap_addr = '0;
  logic [31:0] wr_data = '0;
  logic        other_sel = 1'b0;
  logic        lock_in = 1'b0;
  logic        sec_busy = 1'b0;
  logic        sec_gnt = 1'b0;
  logic        sec_done = 1'b0;
  logic        devsel, stop, trdy, sec_req, sec_start;
  logic [31:0] sec_addr, sec_data;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subtractive_wr_target u_subtractive_wr_target (
    .clk(clk), .rst_n(rst_n), .ap_valid(ap_valid), .ap_cmd(ap_cmd),
    .ap_addr(ap_addr), .wr_data(wr_data), .other_sel(other_sel),
    .lock_in(lock_in), .devsel(devsel), .stop(stop), .trdy(trdy),
    .sec_busy(sec_busy), .sec_gnt(sec_gnt), .sec_req(sec_req),
    .sec_start(sec_start), .sec_addr(sec_addr), .sec_data(sec_data),
    .sec_done(sec_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // drives one address phase; returns just after the address edge
  task automatic addr_phase(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d);
    ap_valid = 1'b1; ap_cmd = cmd; ap_addr = a; wr_data = d;
    step();
    ap_valid = 1'b0;
  endtask

  // {devsel, stop, trdy, sec_start}
  function automatic logic [31:0] outs();
    return {28'd0, devsel, stop, trdy, sec_start};
  endfunction

  task automatic t_reset();
    check("R11 outputs after reset", {27'd0, outs(), sec_req}, 32'd0);
  endtask

  task automatic t_accept_done();
    addr_phase(MEMW, 32'hFFFF_FFF0, 32'hA5A5_0001);
    step(); step();
    check("R1 no select during window", outs(), 32'd0);
    step();
    check("R1/R8 claim and start", outs(), 32'b1001);
    check("R8 sec_addr", sec_addr, 32'hFFFF_FFF0);
    check("R8 sec_data", sec_data, 32'hA5A5_0001);
    step();
    check("R8 wait state", outs(), 32'b1000);
    sec_done = 1'b1;
    step();
    sec_done = 1'b0;
    check("R9 trdy after done", outs(), 32'b1010);
    step();
    check("R9 release", outs(), 32'd0);
  endtask

  task automatic t_other_claims();
    addr_phase(MEMW, 32'h0000_1000, 32'h1);
    step();
    other_sel = 1'b1;
    step();
    other_sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R2 other agent claimed", outs(), 32'd0);
    end
  endtask

  task automatic t_non_write();
    addr_phase(4'b0110, 32'h0000_2000, 32'h2);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R3 non-write ignored", outs(), 32'd0);
    end
  endtask

  task automatic t_busy_retry_then_grant();
    sec_busy = 1'b1;
    addr_phase(MEMW, 32'h0000_3000, 32'h33);
    step(); step(); step();
    check("R4 retry with select", outs(), 32'b1100);
    check("R5 request raised", {31'd0, sec_req}, 32'd1);
    step();
    check("R4 retry one clock", outs(), 32'd0);
    step(); step();
    check("R5 request held", {31'd0, sec_req}, 32'd1);
    sec_gnt = 1'b1;
    step();
    sec_gnt = 1'b0;
    check("R5 request dropped after grant", {31'd0, sec_req}, 32'd0);
    addr_phase(MEMW, 32'h0000_3000, 32'h33);
    step(); step(); step();
    check("R6 accepted while busy", outs(), 32'b1001);
    check("R6 request stays low", {31'd0, sec_req}, 32'd0);
    step(); step(); step();
    check("R10 still waiting", outs(), 32'b1000);
    step();
    check("R10 trdy after standard length", outs(), 32'b1010);
    step();
    check("R10 release", outs(), 32'd0);
    addr_phase(MEMW, 32'h0000_3004, 32'h34);
    step(); step(); step();
    check("R6 grant consumed, retried again", outs(), 32'b1100);
    step();
    sec_gnt = 1'b1;
    step();
    sec_gnt = 1'b0;
    sec_busy = 1'b0;
    step();
  endtask

  task automatic t_lock();
    lock_in = 1'b1;
    step();
    addr_phase(MEMW, 32'h0000_4000, 32'h44);
    step(); step(); step();
    check("R7 locked write retried", outs(), 32'b1100);
    check("R7 no request when bus free", {31'd0, sec_req}, 32'd0);
    lock_in = 1'b0;
    step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_accept_done();
    t_other_claims();
    t_non_write();
    t_lock();
    t_busy_retry_then_grant();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule